// File: doc/BRIEF.md
# Two-Bank Interleaved Burst Reader

This block holds a word-addressed memory split into two banks that can be read at the same time. Even word addresses live in one bank and odd word addresses in the other, so any two consecutive words sit in different banks. A burst read takes a start word address and a length in words. After a fixed row-activation delay, the block reads both banks together on every clock. Each clock it presents a pair of words, a lower lane and an upper lane, and each lane has its own valid flag. The pair stands in for the data a double-data-rate part sends on the rising and the falling edge.

The latency to the first word is the same as for a single-rate reader with the same activation delay. Only the rate after that first word doubles. A burst that starts on an odd address opens with a half beat that carries only the upper word. A burst that ends on an even address closes with a half beat that carries only the lower word. A single-cycle done pulse marks the final beat. A simple write port fills the banks, and it uses the same rule to map an address to a bank.

Top module: `ddr_burst_reader`

## Requirements
- R1: After reset, busy, lo_valid, hi_valid and done are all 0.
- R2: A write stores wr_data in the bank chosen by wr_addr bit 0 (0 selects the even bank, which feeds the lower lane; 1 selects the odd bank, which feeds the upper lane), at in-bank row wr_addr >> 1.
- R3: A start sampled at a clock edge raises busy after that edge. No lane is valid after the next ACT_CYC edges. The first beat is visible after edge ACT_CYC+1 counted from the start edge.
- R4: For an even start address a, every beat except possibly the last shows word w in the lower lane and word w+1 in the upper lane, both valid, starting at w = a. Each following beat advances w by 2, with no idle cycle between beats.
- R5: For an odd start address a, the first beat has only hi_valid set and carries word a. Pairs then follow from word a+1.
- R6: When the words left for the final beat number one and that word has an even address, the final beat has only lo_valid set.
- R7: done is high for exactly the cycle that shows the final beat, and busy falls at that same cycle.
- R8: Word addresses wrap modulo 2^ADDR_W during a burst.
- R9: start is ignored while busy is high, and a start with start_len of 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Word address for a write |
| wr_data | input | DATA_W | Word to write |
| start | input | 1 | Begin a burst |
| start_addr | input | ADDR_W | First word address of the burst |
| start_len | input | LEN_W | Burst length in words |
| busy | output | 1 | A burst is in progress |
| lo_valid | output | 1 | Lower (rising-edge) word is valid |
| lo_data | output | DATA_W | Lower word |
| hi_valid | output | 1 | Upper (falling-edge) word is valid |
| hi_data | output | DATA_W | Upper word |
| done | output | 1 | Final beat of the burst |

## Verification
The bench writes a distinct computed value to every word. It then runs a burst for every start address and every nonzero length, so even and odd starts meet both even and odd lengths. That covers all four combinations of leading and trailing half beats, and bursts that cross the wrap point. Because every word differs, a swapped lane, a wrong bank row or a skipped pair is visible, and the cycle-exact comparison also separates a wrong latency from a wrong order. Separate runs send a start during a burst and a zero-length start, to show that neither one produces a beat.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_RUN} seq_state_t;

  typedef struct packed {
    logic lo_v;
    logic hi_v;
    logic last;
  } beat_flags_t;
endpackage

// File: rtl/bank_ram.sv
module bank_ram #(
  parameter int DATA_W = 16,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W  = 6,
  parameter int LEN_W   = 5,
  parameter int ACT_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       start_addr,
  input  logic [LEN_W-1:0]        start_len,
  output logic                    busy,
  output logic                    rd_en,
  output logic [ADDR_W-2:0]       rd_pair,
  output burst_pkg::beat_flags_t  beat
);
  import burst_pkg::*;

  localparam int PW = ADDR_W - 1;
  localparam int CW = (ACT_CYC > 1) ? $clog2(ACT_CYC) : 1;

  seq_state_t       st;
  logic [CW-1:0]    cnt;
  logic [PW-1:0]    pair;
  logic [LEN_W-1:0] rem, rem_n;
  logic             odd_first;
  logic             lo_take, hi_take;

  // lane usage of the beat issued this cycle
  always_comb begin
    lo_take = !odd_first;
    hi_take = odd_first || (rem > LEN_W'(1));
    rem_n   = rem - {{(LEN_W-1){1'b0}}, lo_take} - {{(LEN_W-1){1'b0}}, hi_take};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      pair      <= '0;
      rem       <= '0;
      odd_first <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start && (start_len != '0)) begin
          st        <= ST_ACT;
          cnt       <= CW'(ACT_CYC - 1);
          pair      <= start_addr[ADDR_W-1:1];
          rem       <= start_len;
          odd_first <= start_addr[0];
        end
        ST_ACT: begin
          if (cnt == '0) st <= ST_RUN;
          else           cnt <= cnt - 1'b1;
        end
        ST_RUN: begin
          pair      <= pair + 1'b1;
          rem       <= rem_n;
          odd_first <= 1'b0;
          if (rem_n == '0) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign rd_en     = (st == ST_RUN);
  assign rd_pair   = pair;
  assign beat.lo_v = rd_en && lo_take;
  assign beat.hi_v = rd_en && hi_take;
  assign beat.last = rd_en && (rem_n == '0);

  // R4: a running burst always has words left to issue
  assert_run_has_words_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) |-> (rem != '0));

  // R3: reads only begin after the activation phase
  assert_act_leads_run_R3: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_RUN) && ($past(st) != ST_RUN)) |-> ($past(st) == ST_ACT));
endmodule

// File: rtl/ddr_burst_reader.sv
module ddr_burst_reader #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 6,
  parameter int LEN_W   = 5,
  parameter int ACT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  output logic              busy,
  output logic              lo_valid,
  output logic [DATA_W-1:0] lo_data,
  output logic              hi_valid,
  output logic [DATA_W-1:0] hi_data,
  output logic              done
);
  import burst_pkg::*;

  localparam int BAW = ADDR_W - 1;

  logic              rd_en;
  logic [BAW-1:0]    rd_pair;
  beat_flags_t       beat;
  logic [DATA_W-1:0] bank_q [2];

  burst_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ACT_CYC(ACT_CYC)
  ) i_seq (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .start_len(start_len), .busy(busy), .rd_en(rd_en),
    .rd_pair(rd_pair), .beat(beat)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    bank_ram #(.DATA_W(DATA_W), .AW(BAW)) i_bank (
      .clk(clk),
      .we(wr_en && (wr_addr[0] == 1'(b))),
      .waddr(wr_addr[ADDR_W-1:1]),
      .wdata(wr_data),
      .re(rd_en),
      .raddr(rd_pair),
      .q(bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_valid <= 1'b0;
      hi_valid <= 1'b0;
      done     <= 1'b0;
    end else begin
      lo_valid <= beat.lo_v;
      hi_valid <= beat.hi_v;
      done     <= beat.last;
    end
  end

  assign lo_data = bank_q[0];
  assign hi_data = bank_q[1];

  // R7: the done pulse rides on a beat
  assert_done_with_beat_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (lo_valid || hi_valid));

  // R5: an upper-only beat is always the first beat of its burst
  assert_hionly_first_R5: assert property (@(posedge clk) disable iff (rst)
    (hi_valid && !lo_valid) |-> !$past(lo_valid || hi_valid));

  // R6: a lower-only beat is always the final beat
  assert_loonly_last_R6: assert property (@(posedge clk) disable iff (rst)
    (lo_valid && !hi_valid) |-> done);

  // R3: every beat belongs to a burst that was already busy
  assert_beat_after_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (lo_valid || hi_valid) |-> $past(busy));
endmodule

// File: tb/test_ddr_burst_reader.sv
module test_ddr_burst_reader;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 6;
  localparam int LEN_W   = 5;
  localparam int ACT_CYC = 2;
  localparam int NWORDS  = 1 << ADDR_W;
  localparam int MAXLEN  = (1 << LEN_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [LEN_W-1:0]  start_len = '0;
  logic              busy, lo_valid, hi_valid, done;
  logic [DATA_W-1:0] lo_data, hi_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ddr_burst_reader #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ACT_CYC(ACT_CYC)
  ) i_ddr_burst_reader (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .start_addr(start_addr), .start_len(start_len),
    .busy(busy), .lo_valid(lo_valid), .lo_data(lo_data),
    .hi_valid(hi_valid), .hi_data(hi_data), .done(done)
  );

  function automatic logic [DATA_W-1:0] pat(int a);
    return DATA_W'((a * 40503 + 7) ^ (a << 9));
  endfunction

  task automatic check(bit ok, string tag, string act, string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string flags_str(logic b, logic l, logic h, logic d);
    return $sformatf("busy=%0b lo_v=%0b hi_v=%0b done=%0b", b, l, h, d);
  endfunction

  // quiet window: no lane valid, busy as given
  task automatic expect_quiet(string tag, logic exp_busy);
    check(busy == exp_busy && !lo_valid && !hi_valid && !done, tag,
          flags_str(busy, lo_valid, hi_valid, done),
          flags_str(exp_busy, 1'b0, 1'b0, 1'b0));
  endtask

  // run a burst and compare every beat cycle by cycle; optionally poke start mid-burst
  task automatic run_burst(int a, int n, bit poke);
    int p, left;
    bit first;
    start = 1'b1; start_addr = ADDR_W'(a); start_len = LEN_W'(n);
    tick();
    start = 1'b0;
    expect_quiet("R3 busy after start", 1'b1);
    for (int i = 1; i <= ACT_CYC; i++) begin
      if (poke && i == 1) begin
        // R9: start while busy must be ignored
        start = 1'b1; start_addr = ADDR_W'(a + 29); start_len = 3;
      end
      tick();
      start = 1'b0;
      expect_quiet("R3 activation window", 1'b1);
    end
    p = a; left = n; first = 1;
    while (left > 0) begin
      logic el, eh, ed;
      logic [DATA_W-1:0] elo, ehi;
      string tag;
      bit ok;
      tick();
      el = 0; eh = 0; elo = '0; ehi = '0;
      tag = "R4";
      if (first && (p % 2 == 1)) begin
        eh = 1; ehi = pat(p % NWORDS); p++; left--; tag = "R5";
      end else begin
        el = 1; elo = pat(p % NWORDS); p++; left--;
        if (left > 0) begin
          eh = 1; ehi = pat(p % NWORDS); p++; left--;
        end else if (!first) tag = "R6";
      end
      if (first) tag = {tag, " R3 first beat"};
      if (p > NWORDS) tag = {tag, " R8 wrap"};
      ed = (left == 0);
      if (ed) tag = {tag, " R7 done"};
      first = 0;
      ok = (lo_valid == el) && (hi_valid == eh) && (done == ed) && (busy == !ed)
           && (!el || lo_data == elo) && (!eh || hi_data == ehi);
      check(ok, $sformatf("%s a=%0d n=%0d", tag, a, n),
            $sformatf("%s lo=%h hi=%h", flags_str(busy, lo_valid, hi_valid, done), lo_data, hi_data),
            $sformatf("%s lo=%h hi=%h", flags_str(!ed, el, eh, ed), elo, ehi));
    end
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    expect_quiet("R1 reset state", 1'b0);

    // R2: fill every word through the write port
    for (int a = 0; a < NWORDS; a++) begin
      wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = pat(a);
      tick();
    end
    wr_en = 1'b0;
    tick();

    // R2 R4 R5 R6 R7 R8: every start address with every nonzero length
    for (int a = 0; a < NWORDS; a++)
      for (int n = 1; n <= MAXLEN; n++)
        run_burst(a, n, 1'b0);

    // R9: start during a burst changes nothing and starts no second burst
    run_burst(4, 6, 1'b1);
    for (int i = 0; i < ACT_CYC + 4; i++) begin
      tick();
      expect_quiet("R9 no burst from start while busy", 1'b0);
    end
    run_burst(33, 7, 1'b1);
    for (int i = 0; i < ACT_CYC + 4; i++) begin
      tick();
      expect_quiet("R9 no burst from start while busy", 1'b0);
    end

    // R9: zero length start is ignored
    start = 1'b1; start_addr = 6'd10; start_len = '0;
    tick();
    start = 1'b0;
    for (int i = 0; i < ACT_CYC + 4; i++) begin
      expect_quiet("R9 zero length ignored", 1'b0);
      tick();
    end

    // R2: overwrite one odd and one even word, read back as a pair
    wr_en = 1'b1; wr_addr = 6'd20; wr_data = 16'hA5C3; tick();
    wr_addr = 6'd21; wr_data = 16'h3C5A; tick();
    wr_en = 1'b0;
    start = 1'b1; start_addr = 6'd20; start_len = 5'd2;
    tick();
    start = 1'b0;
    repeat (ACT_CYC) tick();
    tick();
    check(lo_valid && hi_valid && lo_data == 16'hA5C3 && hi_data == 16'h3C5A,
          "R2 bank mapping after rewrite",
          $sformatf("lo_v=%0b lo=%h hi_v=%0b hi=%h", lo_valid, lo_data, hi_valid, hi_data),
          "lo_v=1 lo=a5c3 hi_v=1 hi=3c5a");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule